// File: doc/BRIEF.md
# Vector Element Insert Unit

This execution unit writes one scalar element into a 128-bit vector value. The element is a byte, a 32-bit dword or a 64-bit qword, and an 8-bit immediate selects its lane. The scalar comes from a 64-bit source. The element is merged into a base vector, and every unselected lane of the low 128 bits passes through unchanged. Vector registers can be wider than 128 bits; the maximum width is the parameter `MAX_W`, which must be at least 128.

There are two encoding forms.
- **Legacy form:** the destination register is both the merge base and the result, and the bits above 127 keep their old value.
- **Three-operand form:** a separate second source vector is the merge base, and the bits above 127 are forced to zero.

Some encodings are illegal and raise an undefined-opcode fault instead of writing:
- a nonzero vector-length field in the three-operand form,
- a qword insert outside 64-bit mode,
- an unknown element-size code.

When a fault is raised, the result carries the destination vector unchanged. The result, the fault and the valid flag are registered one cycle after the request.

Top module: `vins_top`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. The result and fault registers load only on a request.
- R2: When `esize` is 2'b00 (byte), bits [7:0] of `scalar` are written to byte lane `imm[3:0]`. Immediate bits [7:4] have no effect.
- R3: When `esize` is 2'b01 (dword), bits [31:0] of `scalar` are written to 32-bit lane `imm[1:0]`. Immediate bits [7:2] and scalar bits [63:32] have no effect.
- R4: When `esize` is 2'b10 (qword), all 64 bits of `scalar` are written to 64-bit lane `imm[0]`. Immediate bits [7:1] have no effect.
- R5: On a non-faulting request, every byte of result bits [127:0] outside the selected lane equals the same byte of the merge base.
- R6: In the legacy form (`form_3op`=0), the merge base is `dest_vec[127:0]`, and result bits above 127 equal `dest_vec` bits above 127.
- R7: In the three-operand form (`form_3op`=1), the merge base is `src2_vec`, and result bits above 127 are zero.
- R8: A three-operand request with `vlen` nonzero raises `res_fault`.
- R9: A qword request with `mode64`=0 raises `res_fault` in either form.
- R10: `esize` 2'b11 raises `res_fault`.
- R11: When `res_fault` is high, `res_vec` equals the `dest_vec` of that request over its full width.
- R12: After a synchronous reset, `res_valid`, `res_fault` and `res_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| form_3op | input | 1 | 1 = three-operand form, 0 = legacy form |
| mode64 | input | 1 | 1 = 64-bit mode |
| vlen | input | 2 | Vector-length field |
| esize | input | 2 | Element size: 00 byte, 01 dword, 10 qword, 11 illegal |
| imm | input | 8 | Lane-select immediate |
| scalar | input | 64 | Scalar source |
| dest_vec | input | MAX_W | Old destination register value |
| src2_vec | input | 128 | Second source vector (three-operand merge base) |
| res_valid | output | 1 | Result valid |
| res_fault | output | 1 | Undefined-opcode fault |
| res_vec | output | MAX_W | Result vector |

## Verification
Fault suppression and upper-lane handling act on the same request. A faulting three-operand request must leave the upper bits at the destination's value and must not zero them. A legacy qword insert outside 64-bit mode must write no lane, although its lane decode is still active. Directed requests combine a nonzero `vlen` with every element size and both modes. Random requests bias `vlen` and `mode64` so that faults interleave with legal inserts back to back. Every result is compared over the full `MAX_W` width against a bench model, which computes the mask by shifting.

// File: rtl/vins_pkg.sv
package vins_pkg;

    localparam int LOW_W    = 128;
    localparam int LANE_B   = LOW_W / 8;
    localparam int SRC_W    = 64;
    localparam int IMM_W    = 8;
    localparam int VL_W     = 2;

    typedef enum logic [1:0] {
        ES_BYTE  = 2'b00,
        ES_DWORD = 2'b01,
        ES_QWORD = 2'b10,
        ES_BAD   = 2'b11
    } esize_e;

    typedef struct packed {
        logic              form_3op;
        logic              mode64;
        logic [VL_W-1:0]   vlen;
        esize_e            esize;
        logic [IMM_W-1:0]  imm;
    } ctl_t;

    // true when byte k of the low vector belongs to the selected lane
    function automatic logic byte_hit(esize_e es, logic [IMM_W-1:0] im, int k);
        logic [3:0] kb;
        kb = 4'(k);
        case (es)
            ES_BYTE:  return kb == im[3:0];
            ES_DWORD: return kb[3:2] == im[1:0];
            ES_QWORD: return kb[3] == im[0];
            default:  return 1'b0;
        endcase
    endfunction

    // element pattern repeated across all lanes of the low vector
    function automatic logic [LOW_W-1:0] spread(esize_e es, logic [SRC_W-1:0] s);
        case (es)
            ES_BYTE:  return {LANE_B{s[7:0]}};
            ES_DWORD: return {4{s[31:0]}};
            default:  return {2{s}};
        endcase
    endfunction

    function automatic int elem_bytes(esize_e es);
        case (es)
            ES_BYTE:  return 1;
            ES_DWORD: return 4;
            ES_QWORD: return 8;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/vins_lane_dec.sv
module vins_lane_dec
    import vins_pkg::*;
(
    input  esize_e              esize,
    input  logic [IMM_W-1:0]    imm,
    output logic [LANE_B-1:0]   byte_en
);
    for (genvar k = 0; k < LANE_B; k++) begin : g_byte
        assign byte_en[k] = byte_hit(esize, imm, k);
    end

    // R2 R3 R4: exactly one element's worth of bytes is selected
    always_comb begin
        p_lane_width_r2: assert ($countones(byte_en) == elem_bytes(esize))
            else $error("lane width mismatch");
    end
endmodule

// File: rtl/vins_merge.sv
module vins_merge
    import vins_pkg::*;
(
    input  logic [LOW_W-1:0]   base,
    input  logic [LOW_W-1:0]   pattern,
    input  logic [LANE_B-1:0]  byte_en,
    output logic [LOW_W-1:0]   merged
);
    logic [LOW_W-1:0] mask;

    for (genvar k = 0; k < LANE_B; k++) begin : g_mask
        assign mask[k*8 +: 8] = {8{byte_en[k]}};
    end

    assign merged = (base & ~mask) | (pattern & mask);

    // R5: a byte left out of the mask is taken from the base
    for (genvar k = 0; k < LANE_B; k++) begin : g_chk
        always_comb begin
            if (!byte_en[k]) begin
                p_pass_through_r5: assert (merged[k*8 +: 8] == base[k*8 +: 8])
                    else $error("unselected byte altered");
            end
        end
    end
endmodule

// File: rtl/vins_fault.sv
module vins_fault
    import vins_pkg::*;
(
    input  ctl_t  ctl,
    output logic  fault
);
    logic bad_len, bad_q, bad_es;

    assign bad_len = ctl.form_3op && (ctl.vlen != '0);
    assign bad_q   = (ctl.esize == ES_QWORD) && !ctl.mode64;
    assign bad_es  = (ctl.esize == ES_BAD);
    assign fault   = bad_len | bad_q | bad_es;
endmodule

// File: rtl/vins_top.sv
module vins_top
    import vins_pkg::*;
#(
    parameter int MAX_W = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               form_3op,
    input  logic               mode64,
    input  logic [1:0]         vlen,
    input  logic [1:0]         esize,
    input  logic [7:0]         imm,
    input  logic [63:0]        scalar,
    input  logic [MAX_W-1:0]   dest_vec,
    input  logic [127:0]       src2_vec,
    output logic               res_valid,
    output logic               res_fault,
    output logic [MAX_W-1:0]   res_vec
);
    localparam int UP_W = MAX_W - LOW_W;

    ctl_t               ctl;
    logic [LANE_B-1:0]  byte_en;
    logic [LOW_W-1:0]   base, pattern, low_res;
    logic [MAX_W-1:0]   ok_vec, next_vec;
    logic               fault_c;

    initial begin
        if (MAX_W < LOW_W) $error("MAX_W below 128");
    end

    assign ctl.form_3op = form_3op;
    assign ctl.mode64   = mode64;
    assign ctl.vlen     = vlen;
    assign ctl.esize    = esize_e'(esize);
    assign ctl.imm      = imm;

    vins_lane_dec u_dec (
        .esize   (ctl.esize),
        .imm     (ctl.imm),
        .byte_en (byte_en)
    );

    assign base    = ctl.form_3op ? src2_vec : dest_vec[LOW_W-1:0];
    assign pattern = spread(ctl.esize, scalar);

    vins_merge u_mrg (
        .base    (base),
        .pattern (pattern),
        .byte_en (byte_en),
        .merged  (low_res)
    );

    vins_fault u_flt (
        .ctl   (ctl),
        .fault (fault_c)
    );

    if (UP_W > 0) begin : g_upper
        logic [UP_W-1:0] up_res;
        assign up_res = ctl.form_3op ? '0 : dest_vec[MAX_W-1:LOW_W];
        assign ok_vec = {up_res, low_res};
    end else begin : g_noupper
        assign ok_vec = low_res;
    end

    assign next_vec = fault_c ? dest_vec : ok_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_vec   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_fault <= fault_c;
                res_vec   <= next_vec;
            end
        end
    end

    // R1: result valid one cycle after a request
    p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_idle_next_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    // R11: a fault returns the destination untouched
    p_fault_keeps_dest_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fault_c) |=> (res_fault && res_vec == $past(dest_vec)));

    // R8: wrong vector length in the three-operand form faults
    p_len_fault_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && form_3op && vlen != 2'b00) |=> res_fault);

    // R9: qword outside 64-bit mode faults
    p_qword_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && esize == 2'b10 && !mode64) |=> res_fault);

    if (UP_W > 0) begin : g_up_chk
        // R7: three-operand success zeroes upper bits
        p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
            (req_valid && form_3op && !fault_c) |=> (res_vec[MAX_W-1:LOW_W] == '0));
        // R6: legacy form keeps upper bits
        p_upper_keep_r6: assert property (@(posedge clk) disable iff (rst)
            (req_valid && !form_3op) |=>
                (res_vec[MAX_W-1:LOW_W] == $past(dest_vec[MAX_W-1:LOW_W])));
    end
endmodule

// File: tb/vins_top_tb_top.sv
module vins_top_tb_top;
    localparam int MAX_W = 256;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid, form_3op, mode64;
    logic [1:0]       vlen, esize;
    logic [7:0]       imm;
    logic [63:0]      scalar;
    logic [MAX_W-1:0] dest_vec;
    logic [127:0]     src2_vec;
    logic             res_valid, res_fault;
    logic [MAX_W-1:0] res_vec;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    vins_top #(.MAX_W(MAX_W)) dut_i (
        .clk, .rst, .req_valid, .form_3op, .mode64, .vlen, .esize, .imm,
        .scalar, .dest_vec, .src2_vec, .res_valid, .res_fault, .res_vec
    );

    task automatic check(string tag, logic [MAX_W-1:0] got, logic [MAX_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic model_fault(logic f3, logic m64, logic [1:0] vl, logic [1:0] es);
        return (f3 && vl != 0) || (es == 2'b10 && !m64) || (es == 2'b11);
    endfunction

    function automatic logic [MAX_W-1:0] model_vec(logic [MAX_W-1:0] d, logic [127:0] s2,
            logic [63:0] sc, logic [7:0] im, logic [1:0] es, logic f3, logic m64, logic [1:0] vl);
        logic [127:0] ones, src, mask, b;
        logic [MAX_W-1:0] r;
        int w, sel;
        if (model_fault(f3, m64, vl, es)) return d;
        case (es)
            2'b00: begin w = 8;  sel = int'(im[3:0]); end
            2'b01: begin w = 32; sel = int'(im[1:0]); end
            default: begin w = 64; sel = int'(im[0]); end
        endcase
        ones = (128'd1 << w) - 1;
        src  = {64'd0, sc} & ones;
        mask = ones << (sel * w);
        b    = f3 ? s2 : d[127:0];
        r    = f3 ? '0 : d;
        r[127:0] = (b & ~mask) | (src << (sel * w));
        return r;
    endfunction

    function automatic logic [MAX_W-1:0] rnd_wide();
        logic [MAX_W-1:0] v;
        for (int i = 0; i < MAX_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic run(string tag, logic f3, logic m64, logic [1:0] vl, logic [1:0] es,
                       logic [7:0] im, logic [63:0] sc, logic [MAX_W-1:0] d, logic [127:0] s2);
        logic ef;
        @(negedge clk);
        req_valid = 1'b1; form_3op = f3; mode64 = m64; vlen = vl; esize = es;
        imm = im; scalar = sc; dest_vec = d; src2_vec = s2;
        @(negedge clk);
        req_valid = 1'b0;
        ef = model_fault(f3, m64, vl, es);
        check("R1 valid", {{(MAX_W-1){1'b0}}, res_valid}, {{(MAX_W-1){1'b0}}, 1'b1});
        check({tag, " fault"}, {{(MAX_W-1){1'b0}}, res_fault}, {{(MAX_W-1){1'b0}}, ef});
        check({tag, " vec"}, res_vec, model_vec(d, s2, sc, im, es, f3, m64, vl));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog got=expired exp=done");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [MAX_W-1:0] d;
        logic [127:0] s2;
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; form_3op = 1'b0; mode64 = 1'b1; vlen = 2'b00;
        esize = 2'b00; imm = '0; scalar = '0; dest_vec = '0; src2_vec = '0;
        repeat (3) @(negedge clk);
        check("R12 valid", {{(MAX_W-1){1'b0}}, res_valid}, '0);
        check("R12 fault", {{(MAX_W-1){1'b0}}, res_fault}, '0);
        check("R12 vec", res_vec, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", {{(MAX_W-1){1'b0}}, res_valid}, '0);

        d = rnd_wide(); s2 = d[MAX_W-1:MAX_W-128] ^ 128'h5a;
        run("R2 byte15 high imm bits", 0, 1, 0, 2'b00, 8'hFF, 64'h1122334455667788, d, s2);
        run("R2 byte0", 0, 0, 0, 2'b00, 8'h30, 64'hFFFF_FFFF_FFFF_FFAB, d, s2);
        run("R3 dword3", 0, 1, 0, 2'b01, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D, d, s2);
        run("R3 dword1 3op", 1, 0, 0, 2'b01, 8'h05, 64'h0123_4567_89AB_CDEF, d, s2);
        run("R4 qword1", 0, 1, 0, 2'b10, 8'hFF, 64'hA5A5_5A5A_0F0F_F0F0, d, s2);
        run("R4 qword0 3op", 1, 1, 0, 2'b10, 8'hFE, 64'h8000_0000_0000_0001, d, s2);
        run("R5 R6 legacy byte7", 0, 1, 0, 2'b00, 8'h07, 64'h0, '1, s2);
        run("R7 3op zero upper", 1, 1, 0, 2'b00, 8'h09, 64'h77, '1, 128'h0);
        run("R8 vlen fault", 1, 1, 2'b01, 2'b00, 8'h00, 64'h55, d, s2);
        run("R8 vlen3 dword", 1, 0, 2'b11, 2'b01, 8'h02, 64'h55, d, s2);
        run("R8 legacy vlen ignored", 0, 1, 2'b10, 2'b01, 8'h02, 64'h66, d, s2);
        run("R9 legacy qword 32bit", 0, 0, 0, 2'b10, 8'h01, 64'h99, d, s2);
        run("R9 3op qword 32bit", 1, 0, 0, 2'b10, 8'h00, 64'h99, d, s2);
        run("R10 bad esize", 0, 1, 0, 2'b11, 8'h00, 64'h12, d, s2);
        run("R11 3op fault keeps upper", 1, 1, 2'b10, 2'b10, 8'h01, 64'h12, '1, s2);

        for (int i = 0; i < 400; i++) begin
            logic f3, m64;
            logic [1:0] vl, es;
            string tag;
            f3  = 1'($urandom);
            m64 = ($urandom % 4) != 0;
            vl  = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            es  = (($urandom % 8) == 0) ? 2'b11 : 2'($urandom % 3);
            if (model_fault(f3, m64, vl, es)) tag = "R11 rnd";
            else if (es == 2'b00) tag = "R2 rnd";
            else if (es == 2'b01) tag = "R3 rnd";
            else tag = "R4 rnd";
            run(tag, f3, m64, vl, es, 8'($urandom), {32'($urandom), 32'($urandom)},
                rnd_wide(), {32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)});
        end

        @(negedge clk);
        check("R1 idle after", {{(MAX_W-1){1'b0}}, res_valid}, '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule